// File: doc/BRIEF.md
# Hot-Plug I/O Expander Controller

This block lets a switch carry the hot-plug signals of its downstream ports over a shared SMBus instead of dedicated pins. Slot logic presents the desired hot-plug output byte on `hp_out`. The block keeps a shadow of the value last written to the external expander, and whenever the two differ it asks the SMBus master engine for a write carrying the whole output byte. Changes that arrive while a transaction is in flight collapse into a single follow-up write with the newest value.

The expander signals a change on its inputs by pulling an active-low interrupt that reaches the block asynchronously on a pin shared with general purpose I/O. The block synchronizes it and asks for a read of the whole input byte. It then publishes the new input state, the mask of bits that changed, and a one-cycle valid strobe. Reads outrank writes. A NACKed transaction is repeated a bounded number of times before a sticky error flag is raised. The engine is shared with the configuration loader, so the block stays silent until the configuration-done input has been seen.

Top module: `hpx_ctrl`

## Requirements
- R1: After reset `bus_req`, `hp_err` and `hp_chg_vld` are 0 and `hp_in` and `hp_chg` are all zeros. No request is raised until `cfg_done` has been seen high at a clock edge, however much work is pending.
- R2: When the registered copy of `hp_out` differs from the last value written, a write is requested (`bus_rnw` = 0) with `bus_wdata` carrying the whole output byte, not only the changed bits.
- R3: Output changes made while a transaction is in flight produce exactly one follow-up write, and it carries the newest `hp_out` value.
- R4: `exp_int_n` is active low and passes through a two-flop synchronizer. While the synchronized level is low, a read is requested (`bus_rnw` = 1).
- R5: When an interrupt and an output change are both pending at a decision point, the read is requested first.
- R6: After a read that completes without NACK, `hp_in` takes `bus_rdata` and `hp_chg` takes the old `hp_in` XOR `bus_rdata`, both in the cycle after `bus_done`. `hp_chg_vld` is high for exactly that one cycle. At all other times `hp_in` is unchanged.
- R7: If the synchronized interrupt is still low once a read has completed, another read is requested.
- R8: A transaction that ends with `bus_nack` is requested again with the same direction and data, up to 3 times. That is 4 attempts in all. No new transaction is started in between.
- R9: A 4th NACK on the same transaction sets `hp_err`, which then stays set until reset. An abandoned write counts as delivered, so no further write follows until `hp_out` changes. An abandoned read leaves `hp_in` untouched.
- R10: `bus_req`, `bus_rnw` and `bus_wdata` hold steady from the cycle a request is raised until `bus_done` is seen. `bus_req` drops in the cycle after `bus_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_done | input | 1 | Configuration loading finished; enables the block |
| hp_out | input | OUT_W | Desired hot-plug output byte from slot logic |
| exp_int_n | input | 1 | Expander interrupt, active low, asynchronous |
| bus_req | output | 1 | Transaction request to the SMBus master engine |
| bus_rnw | output | 1 | 1 = read input byte, 0 = write output byte |
| bus_wdata | output | OUT_W | Output byte carried by a write |
| bus_done | input | 1 | One-cycle pulse: requested transaction finished |
| bus_nack | input | 1 | Valid with `bus_done`: transaction was NACKed |
| bus_rdata | input | IN_W | Valid with `bus_done`: byte read from the expander |
| hp_in | output | IN_W | Last hot-plug input state read |
| hp_chg | output | IN_W | Bits that changed in the last read (old XOR new) |
| hp_chg_vld | output | 1 | One-cycle strobe marking a fresh `hp_in`/`hp_chg` |
| hp_err | output | 1 | Sticky: a transaction failed after all retries |

## Verification
The bench builds the block with its defaults: byte-wide output and input, three retries and two synchronizer stages. Byte-wide values let patterns such as 0x0F followed by 0xF0 show whole-byte writes and a full XOR mask. The small retry limit means four scripted NACKs are enough to reach both the write and the read abandonment paths. The modelled engine's latency is varied between 3 and 10 cycles, which opens a window for merging output changes and for an interrupt to arrive while a write is still in flight.

// File: rtl/hpx_pkg.sv
package hpx_pkg;
  // Direction of a transaction handed to the SMBus master engine.
  typedef enum logic {
    OP_WR = 1'b0,
    OP_RD = 1'b1
  } hpx_op_e;
endpackage

// File: rtl/hpx_sync.sv
module hpx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  // Idle level of the active-low interrupt is high.
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '1;
    else     sh_q <= {sh_q[STAGES-2:0], din};
  end

  assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/hpx_sched.sv
module hpx_sched
  import hpx_pkg::*;
#(
  parameter int OUT_W     = 8,
  parameter int MAX_RETRY = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_done,
  input  logic             int_act,
  input  logic             wr_pend,
  input  logic [OUT_W-1:0] wr_val,
  input  logic             bus_done,
  input  logic             bus_nack,
  output logic             bus_req,
  output logic             bus_rnw,
  output logic [OUT_W-1:0] bus_wdata,
  output logic             ev_rd_ok,
  output logic             ev_wr_close,
  output logic             hp_err
);
  localparam int TRY_W = (MAX_RETRY < 1) ? 1 : $clog2(MAX_RETRY + 1);

  logic             started_q;
  logic             retry_q;
  logic             req_q;
  logic             err_q;
  hpx_op_e          op_q;
  logic [TRY_W-1:0] tries_q;
  logic [OUT_W-1:0] data_q;

  logic fin, give_up;

  assign fin     = req_q && bus_done;
  assign give_up = fin && bus_nack && (tries_q == TRY_W'(MAX_RETRY));

  always_ff @(posedge clk) begin
    if (rst) begin
      started_q <= 1'b0;
      retry_q   <= 1'b0;
      req_q     <= 1'b0;
      err_q     <= 1'b0;
      op_q      <= OP_WR;
      tries_q   <= '0;
      data_q    <= '0;
    end else begin
      started_q <= started_q | cfg_done;
      if (!req_q) begin
        if (started_q) begin
          // A pending retry repeats the same operation; then reads, then writes.
          if (retry_q) begin
            req_q   <= 1'b1;
            retry_q <= 1'b0;
          end else if (int_act) begin
            req_q   <= 1'b1;
            op_q    <= OP_RD;
            tries_q <= '0;
          end else if (wr_pend) begin
            req_q   <= 1'b1;
            op_q    <= OP_WR;
            data_q  <= wr_val;
            tries_q <= '0;
          end
        end
      end else if (bus_done) begin
        req_q <= 1'b0;
        if (bus_nack) begin
          if (give_up) begin
            err_q <= 1'b1;
          end else begin
            tries_q <= tries_q + 1'b1;
            retry_q <= 1'b1;
          end
        end
      end
    end
  end

  assign bus_req     = req_q;
  assign bus_rnw     = (op_q == OP_RD);
  assign bus_wdata   = data_q;
  assign hp_err      = err_q;
  assign ev_rd_ok    = fin && !bus_nack && (op_q == OP_RD);
  assign ev_wr_close = fin && (op_q == OP_WR) && (!bus_nack || give_up);

  // R10: request fields stay put until the engine answers.
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_done |=> bus_req && $stable(bus_rnw) && $stable(bus_wdata));

  // R10 / R8: the request is released for a cycle after every completion.
  assert_req_gap_R8: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_done |=> !bus_req);

  // R1: silent until configuration loading has been observed.
  assert_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !started_q |-> !bus_req);

  // R9: the error flag only rises right after a NACKed completion.
  assert_err_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(hp_err) |-> $past(bus_done && bus_nack));

  // R5: a fresh decision taken with the interrupt active is a read.
  assert_read_first_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) && $past(int_act) && !$past(retry_q) |-> bus_rnw);
endmodule

// File: rtl/hpx_track.sv
module hpx_track #(
  parameter int                 OUT_W   = 8,
  parameter int                 IN_W    = 8,
  parameter logic [OUT_W-1:0]   OUT_RST = '0,
  parameter logic [IN_W-1:0]    IN_RST  = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OUT_W-1:0] hp_out,
  input  logic             ev_wr_close,
  input  logic [OUT_W-1:0] close_data,
  input  logic             ev_rd_ok,
  input  logic [IN_W-1:0]  bus_rdata,
  output logic             wr_pend,
  output logic [OUT_W-1:0] wr_val,
  output logic [IN_W-1:0]  hp_in,
  output logic [IN_W-1:0]  hp_chg,
  output logic             hp_chg_vld
);
  logic [OUT_W-1:0] want_q;
  logic [OUT_W-1:0] sent_q;
  logic [IN_W-1:0]  in_q;
  logic [IN_W-1:0]  chg_q;
  logic             vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      want_q <= OUT_RST;
      sent_q <= OUT_RST;
      in_q   <= IN_RST;
      chg_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      want_q <= hp_out;
      if (ev_wr_close) sent_q <= close_data;
      vld_q <= ev_rd_ok;
      if (ev_rd_ok) begin
        in_q  <= bus_rdata;
        chg_q <= in_q ^ bus_rdata;
      end
    end
  end

  // Comparing against the last delivered byte merges any number of changes.
  assign wr_pend    = (want_q != sent_q);
  assign wr_val     = want_q;
  assign hp_in      = in_q;
  assign hp_chg     = chg_q;
  assign hp_chg_vld = vld_q;

  // R6: strobe lasts one cycle.
  assert_vld_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    hp_chg_vld |=> !hp_chg_vld);

  // R6: mask equals old state XOR new state.
  assert_chg_mask_R6: assert property (@(posedge clk) disable iff (rst)
    hp_chg_vld |-> hp_chg == (hp_in ^ $past(hp_in)));

  // R6 / R9: input state only moves together with the strobe.
  assert_in_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !hp_chg_vld |-> $stable(hp_in));
endmodule

// File: rtl/hpx_ctrl.sv
module hpx_ctrl #(
  parameter int               OUT_W       = 8,
  parameter int               IN_W        = 8,
  parameter int               MAX_RETRY   = 3,
  parameter int               SYNC_STAGES = 2,
  parameter logic [OUT_W-1:0] OUT_RST     = '0,
  parameter logic [IN_W-1:0]  IN_RST      = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_done,
  input  logic [OUT_W-1:0] hp_out,
  input  logic             exp_int_n,
  output logic             bus_req,
  output logic             bus_rnw,
  output logic [OUT_W-1:0] bus_wdata,
  input  logic             bus_done,
  input  logic             bus_nack,
  input  logic [IN_W-1:0]  bus_rdata,
  output logic [IN_W-1:0]  hp_in,
  output logic [IN_W-1:0]  hp_chg,
  output logic             hp_chg_vld,
  output logic             hp_err
);
  logic             int_sync_n;
  logic             wr_pend;
  logic [OUT_W-1:0] wr_val;
  logic             ev_rd_ok;
  logic             ev_wr_close;

  hpx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (exp_int_n),
    .dout (int_sync_n)
  );

  hpx_sched #(.OUT_W(OUT_W), .MAX_RETRY(MAX_RETRY)) u_sched (
    .clk         (clk),
    .rst         (rst),
    .cfg_done    (cfg_done),
    .int_act     (!int_sync_n),
    .wr_pend     (wr_pend),
    .wr_val      (wr_val),
    .bus_done    (bus_done),
    .bus_nack    (bus_nack),
    .bus_req     (bus_req),
    .bus_rnw     (bus_rnw),
    .bus_wdata   (bus_wdata),
    .ev_rd_ok    (ev_rd_ok),
    .ev_wr_close (ev_wr_close),
    .hp_err      (hp_err)
  );

  hpx_track #(.OUT_W(OUT_W), .IN_W(IN_W), .OUT_RST(OUT_RST), .IN_RST(IN_RST)) u_track (
    .clk         (clk),
    .rst         (rst),
    .hp_out      (hp_out),
    .ev_wr_close (ev_wr_close),
    .close_data  (bus_wdata),
    .ev_rd_ok    (ev_rd_ok),
    .bus_rdata   (bus_rdata),
    .wr_pend     (wr_pend),
    .wr_val      (wr_val),
    .hp_in       (hp_in),
    .hp_chg      (hp_chg),
    .hp_chg_vld  (hp_chg_vld)
  );

  // R2: a newly raised write carries the output byte seen two cycles earlier.
  assert_wr_byte_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) && !bus_rnw && !$past(bus_req, 2) |-> bus_wdata == $past(hp_out, 2));
endmodule

// File: tb/hpx_ctrl_bench.sv
module hpx_ctrl_bench;
  localparam int W      = 8;
  localparam int NRETRY = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cfg_done = 1'b0;
  logic         exp_int_n = 1'b1;
  logic         bus_done = 1'b0;
  logic         bus_nack = 1'b0;
  logic [W-1:0] hp_out = '0;
  logic [W-1:0] bus_rdata = '0;
  logic         bus_req, bus_rnw, hp_chg_vld, hp_err;
  logic [W-1:0] bus_wdata, hp_in, hp_chg;

  always #2 clk = ~clk;

  hpx_ctrl u_hpx_ctrl (
    .clk(clk), .rst(rst), .cfg_done(cfg_done), .hp_out(hp_out), .exp_int_n(exp_int_n),
    .bus_req(bus_req), .bus_rnw(bus_rnw), .bus_wdata(bus_wdata),
    .bus_done(bus_done), .bus_nack(bus_nack), .bus_rdata(bus_rdata),
    .hp_in(hp_in), .hp_chg(hp_chg), .hp_chg_vld(hp_chg_vld), .hp_err(hp_err)
  );

  int compared = 0;
  int mism = 0;
  bit fin_flag = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mism++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model, advanced on every rising edge ----------------
  logic         m_s1, m_s2, m_started, m_req, m_rnw, m_vld, m_err, m_rp;
  logic [W-1:0] m_want, m_sent, m_in, m_chg, m_data;
  int           m_tries;

  always @(posedge clk) begin
    logic         o_s1, o_s2, o_started, o_req, o_rnw, o_rp;
    logic [W-1:0] o_want, o_sent, o_in, o_data;
    int           o_tries;
    if (rst) begin
      m_s1 = 1; m_s2 = 1; m_started = 0; m_req = 0; m_rnw = 0; m_vld = 0; m_err = 0; m_rp = 0;
      m_want = 0; m_sent = 0; m_in = 0; m_chg = 0; m_data = 0; m_tries = 0;
    end else begin
      o_s1 = m_s1; o_s2 = m_s2; o_started = m_started; o_req = m_req; o_rnw = m_rnw;
      o_rp = m_rp; o_want = m_want; o_sent = m_sent; o_in = m_in; o_data = m_data; o_tries = m_tries;
      m_s1 = exp_int_n;
      m_s2 = o_s1;
      m_want = hp_out;
      m_started = o_started | cfg_done;
      m_vld = 0;
      if (!o_req && o_started) begin
        if (o_rp) begin m_req = 1; m_rp = 0; end
        else if (!o_s2) begin m_req = 1; m_rnw = 1; m_tries = 0; end
        else if (o_want != o_sent) begin m_req = 1; m_rnw = 0; m_data = o_want; m_tries = 0; end
      end else if (o_req && bus_done) begin
        m_req = 0;
        if (bus_nack) begin
          if (o_tries == NRETRY) begin
            m_err = 1;
            if (!o_rnw) m_sent = o_data;
          end else begin
            m_tries = o_tries + 1;
            m_rp = 1;
          end
        end else if (o_rnw) begin
          m_in = bus_rdata; m_chg = o_in ^ bus_rdata; m_vld = 1;
        end else begin
          m_sent = o_data;
        end
      end
    end
  end

  // ---------------- comparison and transaction log ----------------
  bit           op_log[$];
  logic [W-1:0] dat_log[$];
  int           n_rd = 0, n_wr = 0;
  logic         prev_req = 0;

  initial forever begin
    @(negedge clk);
    if (!rst) begin
      chk("R10 bus_req", 32'(bus_req), 32'(m_req));
      if (m_req) begin
        chk("R4 bus_rnw", 32'(bus_rnw), 32'(m_rnw));
        if (!m_rnw) chk("R2 bus_wdata", 32'(bus_wdata), 32'(m_data));
      end
      chk("R6 hp_in", 32'(hp_in), 32'(m_in));
      chk("R6 hp_chg", 32'(hp_chg), 32'(m_chg));
      chk("R6 hp_chg_vld", 32'(hp_chg_vld), 32'(m_vld));
      chk("R9 hp_err", 32'(hp_err), 32'(m_err));
      if (bus_req && !prev_req) begin
        op_log.push_back(bus_rnw);
        dat_log.push_back(bus_wdata);
        if (bus_rnw) n_rd++; else n_wr++;
      end
    end
    prev_req = bus_req;
  end

  // ---------------- SMBus engine and expander model ----------------
  int           lat = 3;
  int           nack_left = 0;
  int           cnt = 0;
  bit           rel_en = 1;
  logic [W-1:0] exp_in = '0;

  initial forever begin
    @(negedge clk);
    if (rst) begin
      cnt = 0; bus_done = 0; bus_nack = 0;
    end else if (bus_done) begin
      bus_done = 0; bus_nack = 0; cnt = 0;
    end else if (bus_req) begin
      cnt++;
      if (cnt == 1 && bus_rnw && rel_en) exp_int_n = 1;   // expander clears on read
      if (cnt >= lat) begin
        bus_done = 1;
        bus_rdata = exp_in;
        if (nack_left > 0) begin bus_nack = 1; nack_left--; end
        else bus_nack = 0;
      end
    end else begin
      cnt = 0;
    end
  end

  task automatic clear_logs();
    op_log.delete(); dat_log.delete(); n_rd = 0; n_wr = 0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    int guard = 0;
    while (q < 12 && guard < 5000) begin
      @(negedge clk);
      guard++;
      if (bus_req || bus_done) q = 0; else q++;
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin_flag) begin
      compared++; mism++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset bus_req", 32'(bus_req), 32'h0);
    chk("R1 reset hp_in", 32'(hp_in), 32'h0);
    chk("R1 reset hp_err", 32'(hp_err), 32'h0);

    // R1 + R5: work piles up before configuration is done; read must go first
    hp_out = 8'h3C; exp_in = 8'hA5; exp_int_n = 0;
    repeat (20) @(negedge clk);
    chk("R1 silent before cfg_done", 32'(n_rd + n_wr), 32'h0);
    cfg_done = 1;
    wait_quiet();
    chk("R5 first op is read", 32'(op_log.size() > 0 ? op_log[0] : 1'b0), 32'h1);
    chk("R2 one write", 32'(n_wr), 32'h1);
    chk("R2 full byte", 32'(dat_log[dat_log.size()-1]), 32'h3C);
    chk("R6 input published", 32'(hp_in), 32'hA5);

    // R2: single change
    clear_logs();
    hp_out = 8'h5A;
    wait_quiet();
    chk("R2 write count", 32'(n_wr), 32'h1);
    chk("R2 write byte", 32'(dat_log[0]), 32'h5A);

    // R3: changes during flight merge into one follow-up write
    clear_logs();
    lat = 10;
    hp_out = 8'h01;
    while (!bus_req) @(negedge clk);
    hp_out = 8'h02;
    repeat (2) @(negedge clk);
    hp_out = 8'h03;
    wait_quiet();
    chk("R3 merged write count", 32'(n_wr), 32'h2);
    chk("R3 first byte", 32'(dat_log[0]), 32'h01);
    chk("R3 follow-up byte", 32'(dat_log[1]), 32'h03);

    // R5: interrupt and output change arrive during a write
    clear_logs();
    lat = 8;
    hp_out = 8'h11;
    while (!bus_req) @(negedge clk);
    exp_in = 8'h5C; exp_int_n = 0; hp_out = 8'h22;
    wait_quiet();
    chk("R5 op count", 32'(op_log.size()), 32'h3);
    chk("R5 read before pending write", 32'(op_log[1]), 32'h1);
    chk("R5 last write byte", 32'(dat_log[2]), 32'h22);
    lat = 3;

    // R4 / R6: change masks
    exp_in = 8'h0F; exp_int_n = 0;
    wait_quiet();
    chk("R4 read result", 32'(hp_in), 32'h0F);
    exp_in = 8'hF0; exp_int_n = 0;
    wait_quiet();
    chk("R6 change mask", 32'(hp_chg), 32'hFF);

    // R7: interrupt held low keeps reads coming
    clear_logs();
    rel_en = 0; exp_in = 8'h33; exp_int_n = 0;
    for (int g = 0; g < 2000 && n_rd < 3; g++) @(negedge clk);
    rel_en = 1;
    wait_quiet();
    chk("R7 repeated reads", 32'(n_rd >= 3), 32'h1);

    // R8: two NACKs then success
    clear_logs();
    nack_left = 2; hp_out = 8'h44;
    wait_quiet();
    chk("R8 attempts", 32'(n_wr), 32'h3);
    chk("R8 retry byte", 32'(dat_log[2]), 32'h44);
    chk("R8 no error", 32'(hp_err), 32'h0);

    // R9: write abandoned after four NACKs
    clear_logs();
    nack_left = 4; hp_out = 8'h55;
    wait_quiet();
    chk("R9 attempts", 32'(n_wr), 32'h4);
    chk("R9 error set", 32'(hp_err), 32'h1);
    repeat (20) @(negedge clk);
    chk("R9 no rewrite", 32'(n_wr), 32'h4);
    hp_out = 8'h66;
    wait_quiet();
    chk("R9 later write", 32'(dat_log[dat_log.size()-1]), 32'h66);
    chk("R9 error sticky", 32'(hp_err), 32'h1);

    // R9: read abandoned leaves input state alone
    clear_logs();
    nack_left = 4; exp_in = 8'h99; exp_int_n = 0;
    wait_quiet();
    chk("R9 read attempts", 32'(n_rd), 32'h4);
    chk("R9 input untouched", 32'(hp_in), 32'h33);

    fin_flag = 1;
    summary();
    $finish;
  end
endmodule